// File: doc/BRIEF.md
# Load Alias Tracker

This block lets a scheduler hoist a load above stores that might write the same location. When such an early load issues, it records its destination register and address in a small associative table. Every store seen afterwards is compared against all recorded addresses, and any entry it matches is cleared. When the program later reaches the point where the load originally stood, it issues a check for that register. The table answers in one of three ways:

- the early value is still good and nothing needs to happen;
- the load must be repeated from memory;
- the code must jump to a recovery sequence. This is for the case where uses of the early value were themselves hoisted above the check.

The table holds a fixed number of entries, and each entry is keyed by destination register. A register can own only one entry at a time. When the table is full, a new register takes a slot chosen round-robin. A check always frees the entry it looks at. Within one clock cycle, the three operations are ordered: check first, then store, then allocation. The memory itself lies outside the block.

Top module: `load_alias_tracker`

## Requirements
- R1: A synchronous active-high reset clears every entry and drives all result outputs low. Entries recorded before a reset are gone after it, so a check on such a register reports aliasing.
- R2: A check presented in cycle N produces `res_valid` high in cycle N+1 only. In that cycle exactly one of `res_clean`, `res_reload`, `res_branch` is high. All four are low in cycles that follow no check.
- R3: A check on a register whose entry is still valid reports `res_clean`.
- R4: A store clears an entry when address bits [ADDR_W-1:3] of the store equal those of the entry (8-byte granule). A store to a different granule leaves the entry intact.
- R5: One store clears, in the same cycle, every valid entry whose granule matches.
- R6: An aliased check with `chk_branch`=0 reports `res_reload`. An aliased check with `chk_branch`=1 reports `res_branch`.
- R7: A check on a register with no entry is treated as aliased.
- R8: A check frees the entry it examines, whatever the result. A second check on the same register, with no new allocation in between, reports aliasing.
- R9: An allocation to a register that already owns a valid entry overwrites that entry. Only the new address is monitored afterwards.
- R10: Allocation uses the lowest-numbered free slot. When all slots are valid, it evicts the slot named by a round-robin pointer. The pointer starts at 0 and advances by one on each eviction only.
- R11: A store and an allocation in the same cycle to the same granule leave the new entry valid, while still clearing older matching entries.
- R12: A check sees the table as it stood before any store or allocation of the same cycle. A store and a check in the same cycle therefore yield `res_clean` for an intact entry. An allocation in the same cycle as a check on the same register installs a fresh valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Early load records an entry this cycle |
| alloc_reg | input | REG_W | Destination register of the early load |
| alloc_addr | input | ADDR_W | Byte address of the early load |
| store_valid | input | 1 | A store address is presented this cycle |
| store_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | A check is presented this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_branch | input | 1 | 1: recovery-branch form, 0: reload form |
| res_valid | output | 1 | Result of last cycle's check |
| res_clean | output | 1 | Early value is good, no action |
| res_reload | output | 1 | Repeat the load from memory |
| res_branch | output | 1 | Jump to recovery code |

## Verification
The assertions take for granted that the inputs are driven to known values in every cycle, including the reset cycles. In particular, `chk_branch` must hold a defined value so that comparing a result with the form of the previous cycle is meaningful.

The bench changes every input only on the falling edge of the clock and returns each strobe to zero after one cycle. Every check therefore maps to exactly one result cycle. The bench drives reset for whole cycles from time zero, so no property observes a cycle from before reset.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef struct packed {
    logic clean;
    logic reload;
    logic branch;
  } chk_res_t;
endpackage

// File: rtl/lat_match.sv
module lat_match #(
  parameter int N = 16,
  parameter int W = 8
) (
  input  logic [W-1:0]        key_i,
  input  logic [N-1:0][W-1:0] keys_i,
  output logic [N-1:0]        hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = (keys_i[g] == key_i);
  end
endmodule

// File: rtl/lat_slot_pick.sv
module lat_slot_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     same_i,
  output logic [IDX_W-1:0] slot_o
);
  logic [IDX_W-1:0] rr_q, same_idx, free_idx;
  logic             any_same, any_free, evict;

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < N; i++)
      if (same_i[i]) same_idx = IDX_W'(i);
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!valid_i[i]) free_idx = IDX_W'(i);
  end

  assign any_same = |same_i;
  assign any_free = ~&valid_i;
  assign evict    = take_i && !any_same && !any_free;
  assign slot_o   = any_same ? same_idx : (any_free ? free_idx : rr_q);

  always_ff @(posedge clk) begin
    if (rst)
      rr_q <= '0;
    else if (evict)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end

  // R10: the round-robin pointer only moves on an eviction
  a_r10_rr_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(take_i) |-> $stable(rr_q));
endmodule

// File: rtl/load_alias_tracker.sv
module load_alias_tracker
  import lat_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int REG_W    = 7,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_branch,
  output logic              res_valid,
  output logic              res_clean,
  output logic              res_reload,
  output logic              res_branch
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int GW    = ADDR_W - GRAN_LSB;

  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][REG_W-1:0] tag_q;
  logic [ENTRIES-1:0][GW-1:0]    gran_q;
  logic [ENTRIES-1:0]            chk_raw, alloc_raw, store_raw;
  logic [ENTRIES-1:0]            chk_vec, alloc_same, store_vec;
  logic [IDX_W-1:0]              slot;
  logic                          chk_found;
  chk_res_t                      res_d;
  logic                          unused_low_bits;

  assign unused_low_bits = ^{alloc_addr[GRAN_LSB-1:0], store_addr[GRAN_LSB-1:0]};

  lat_match #(.N(ENTRIES), .W(REG_W)) i_chk_match (
    .key_i(chk_reg), .keys_i(tag_q), .hit_o(chk_raw));
  lat_match #(.N(ENTRIES), .W(REG_W)) i_alloc_match (
    .key_i(alloc_reg), .keys_i(tag_q), .hit_o(alloc_raw));
  lat_match #(.N(ENTRIES), .W(GW)) i_store_match (
    .key_i(store_addr[ADDR_W-1:GRAN_LSB]), .keys_i(gran_q), .hit_o(store_raw));

  assign chk_vec    = chk_raw & valid_q;
  assign alloc_same = alloc_raw & valid_q;
  assign store_vec  = store_raw & valid_q;
  assign chk_found  = |chk_vec;

  lat_slot_pick #(.N(ENTRIES), .IDX_W(IDX_W)) i_pick (
    .clk(clk), .rst(rst), .take_i(alloc_valid),
    .valid_i(valid_q), .same_i(alloc_same), .slot_o(slot));

  // per-cycle order: check, then store, then allocation
  always_comb begin
    valid_d = valid_q;
    if (chk_valid)   valid_d = valid_d & ~chk_vec;
    if (store_valid) valid_d = valid_d & ~store_vec;
    if (alloc_valid) valid_d[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= valid_d;
  end

  // payload storage: written on allocation only, no reset needed
  always_ff @(posedge clk) begin
    if (alloc_valid) begin
      tag_q[slot]  <= alloc_reg;
      gran_q[slot] <= alloc_addr[ADDR_W-1:GRAN_LSB];
    end
  end

  always_comb begin
    res_d.clean  = chk_valid && chk_found;
    res_d.reload = chk_valid && !chk_found && !chk_branch;
    res_d.branch = chk_valid && !chk_found && chk_branch;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_clean  <= 1'b0;
      res_reload <= 1'b0;
      res_branch <= 1'b0;
    end else begin
      res_valid  <= chk_valid;
      res_clean  <= res_d.clean;
      res_reload <= res_d.reload;
      res_branch <= res_d.branch;
    end
  end

  // R1: nothing reported in the cycle following reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !res_valid);
  // R2: one-cycle latency of the result strobe
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !(res_valid || res_clean || res_reload || res_branch));
  // R2: exactly one outcome per result
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({res_clean, res_reload, res_branch}));
  // R6: outcome form follows the form requested by the check
  a_r6_branch_form: assert property (@(posedge clk) disable iff (rst)
    res_branch |-> $past(chk_branch));
  a_r6_reload_form: assert property (@(posedge clk) disable iff (rst)
    res_reload |-> !$past(chk_branch));
  // R9: a register never owns two valid entries
  a_r9_unique_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chk_vec));
endmodule

// File: tb/test_load_alias_tracker.sv
`timescale 1ns/1ps
module test_load_alias_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_valid = 0, store_valid = 0, chk_valid = 0, chk_branch = 0;
  logic [6:0]  alloc_reg = '0, chk_reg = '0;
  logic [31:0] alloc_addr = '0, store_addr = '0;
  logic res_valid, res_clean, res_reload, res_branch;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  int    exp_kind[$];   // 0 clean, 1 reload, 2 branch
  string exp_tag[$];

  always #4 clk = ~clk;

  load_alias_tracker i_load_alias_tracker (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
    .store_valid(store_valid), .store_addr(store_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_branch(chk_branch),
    .res_valid(res_valid), .res_clean(res_clean),
    .res_reload(res_reload), .res_branch(res_branch));

  task automatic report(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // monitor: pop the scoreboard whenever a result appears
  initial forever begin
    @(negedge clk);
    if (!rst && res_valid) begin
      int act;
      if ($countones({res_clean, res_reload, res_branch}) != 1) act = 3;
      else act = res_clean ? 0 : (res_reload ? 1 : 2);
      if (exp_kind.size() == 0) report("R2 unexpected result", act, -1);
      else begin
        int e;
        string t;
        e = exp_kind.pop_front();
        t = exp_tag.pop_front();
        report(t, act, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    alloc_valid = 0; store_valid = 0; chk_valid = 0; chk_branch = 0;
  endtask

  task automatic do_alloc(int r, int a);
    alloc_valid = 1; alloc_reg = 7'(r); alloc_addr = 32'(a);
  endtask

  task automatic do_store(int a);
    store_valid = 1; store_addr = 32'(a);
  endtask

  task automatic do_chk(int r, bit br, bit intact, string tag);
    chk_valid = 1; chk_reg = 7'(r); chk_branch = br;
    exp_kind.push_back(intact ? 0 : (br ? 2 : 1));
    exp_tag.push_back(tag);
  endtask

  task automatic apply_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  initial begin
    tick(); tick(); rst = 0;
    // R1: reset state at the outputs
    report("R1 res_valid after reset", int'(res_valid), 0);
    report("R1 outputs after reset", int'({res_clean, res_reload, res_branch}), 0);
    tick();
    report("R2 idle cycle quiet", int'(res_valid), 0);
    do_chk(5, 0, 0, "R7 empty table check"); tick();
    // R3 and R8
    do_alloc(1, 'h100); tick();
    do_chk(1, 0, 1, "R3 intact entry clean"); tick();
    do_chk(1, 0, 0, "R8 entry consumed"); tick();
    // R4 same granule, R6 branch form
    do_alloc(2, 'h200); tick();
    do_store('h204); tick();
    do_chk(2, 1, 0, "R4 R6 same granule branch"); tick();
    do_alloc(3, 'h300); tick();
    do_store('h308); tick();
    do_chk(3, 0, 1, "R4 other granule kept"); tick();
    // R5 multiple matches
    do_alloc(4, 'h400); tick();
    do_alloc(5, 'h404); tick();
    do_alloc(6, 'h500); tick();
    do_store('h400); tick();
    do_chk(4, 0, 0, "R5 first match reload"); tick();
    do_chk(5, 1, 0, "R5 second match branch"); tick();
    do_chk(6, 0, 1, "R5 non-match kept"); tick();
    // R9 replacement
    do_alloc(7, 'h600); tick();
    do_alloc(7, 'h700); tick();
    do_store('h600); tick();
    do_chk(7, 0, 1, "R9 old address unmonitored"); tick();
    do_alloc(8, 'h800); tick();
    do_alloc(8, 'h900); tick();
    do_store('h900); tick();
    do_chk(8, 0, 0, "R9 new address monitored"); tick();
    // R11 same-cycle store and allocation
    do_alloc(10, 'hA00); tick();
    do_alloc(9, 'hA00); do_store('hA00); tick();
    do_chk(9, 0, 1, "R11 new entry survives"); tick();
    do_chk(10, 1, 0, "R11 older match cleared"); tick();
    // R12 check ordered before store and allocation
    do_alloc(11, 'hB00); tick();
    do_chk(11, 0, 1, "R12 check before store"); do_store('hB00); tick();
    do_alloc(12, 'hC00); tick();
    do_chk(12, 0, 1, "R12 check sees old entry"); do_alloc(12, 'hD00); tick();
    do_chk(12, 0, 1, "R12 same-cycle allocation kept"); tick();
    // R1 reset drops entries
    do_alloc(30, 'hE00); tick();
    apply_reset();
    do_chk(30, 0, 0, "R1 entry lost on reset"); tick();
    // R10 fill and round-robin eviction
    for (int k = 0; k < 16; k++) begin
      do_alloc(40 + k, 'h1000 + 16 * k); tick();
    end
    do_alloc(70, 'h2000); tick();
    do_alloc(71, 'h2100); tick();
    do_chk(40, 0, 0, "R10 slot0 evicted"); tick();
    do_chk(41, 1, 0, "R10 slot1 evicted"); tick();
    do_chk(42, 0, 1, "R10 slot2 kept"); tick();
    do_chk(70, 0, 1, "R10 first newcomer"); tick();
    do_chk(71, 0, 1, "R10 second newcomer"); tick();
    // slots 0..2 now free: next allocation takes lowest free, no eviction
    do_alloc(72, 'h2200); tick();
    do_chk(55, 0, 1, "R10 slot15 kept"); tick();
    do_chk(72, 0, 1, "R10 free slot used"); tick();
    tick(); tick();
    report("R2 all results seen", exp_kind.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule